// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block translates 32-bit virtual addresses into physical addresses for a processor pipeline stage. It keeps a small table of recent page mappings. Each mapping is tagged with both a virtual page number and the identifier of the process that owns it. A lookup compares the request against every slot in the same cycle. The result comes back combinationally: a hit with the physical address, or one of three fault kinds. Entries from different processes can sit side by side, so a context switch only changes the identifier on the lookup port and needs no flush.

The top three virtual address bits choose a segment. User addresses (top bit clear) and kernel virtual addresses (top bits `11`) go through the table. The two kernel physical windows (top bits `100` and `101`) bypass it: the physical address is the virtual address with its top three bits cleared, and only the cacheability differs. The block never walks page tables. A miss raises a fault, and refill software installs entries through an indexed write port. A separate port invalidates one slot or every slot. On each successful translated access the hardware also records that the page was referenced, and for a store, that it was modified.

Top module: `tlb_xlate`

## Requirements
- R1: After a synchronous active-low reset every slot is invalid, so any translated lookup reports a miss fault.
- R2: A translated lookup whose page number (VA[31:12]) and process identifier both equal those of a valid slot gives hit=1, cacheable=1 and PA = {slot frame, VA[11:0]}.
- R3: A slot matches only its own process identifier. Two slots with the same page number and different identifiers each return their own frame.
- R4: VA[31]=0 (user segment) and VA[31:30]=11 (kernel virtual segment) are both translated through the table.
- R5: In kernel mode, VA[31:29]=100 gives hit=1, cacheable=1 and PA = VA with bits 31:29 cleared, whatever the table holds. VA[31:29]=101 gives the same except cacheable=0.
- R6: A user-mode request with VA[31]=1 raises only the address fault: no hit, no table search.
- R7: A store that matches a slot whose writable bit is 0 raises the protection fault instead of a hit. A load to the same slot hits.
- R8: A translated request that matches no valid slot raises only the miss fault.
- R9: At most one of hit, miss fault, protection fault and address fault is high. With the request strobe low, all four are low. PA and cacheable read 0 whenever hit is low.
- R10: A single-slot invalidate clears that slot, and the all-slot invalidate clears every slot. An invalidate wins over a write to the same slot in the same cycle.
- R11: The dirty and referenced outputs show the matched slot's stored bits as they were before the access. After a hit the referenced bit becomes 1, and after a store hit the dirty bit becomes 1. A software write to that slot in the same cycle takes precedence.
- R12: When several valid slots match, the lowest-numbered one is used.
- R13: A write replaces every field of the addressed slot and makes it valid, so the old mapping of that slot stops matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request strobe |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | 6 | Process identifier of the request |
| lk_store | input | 1 | 1 for a store, 0 for a load or fetch |
| lk_user | input | 1 | 1 when the request comes from user mode |
| lk_hit | output | 1 | Translation succeeded |
| lk_pa | output | 32 | Physical address (0 unless hit) |
| lk_cacheable | output | 1 | Access may be cached (0 unless hit) |
| lk_dirty | output | 1 | Stored modified bit of the matched slot |
| lk_ref | output | 1 | Stored referenced bit of the matched slot |
| lk_miss_fault | output | 1 | No slot matched |
| lk_prot_fault | output | 1 | Store to a read-only page |
| lk_addr_fault | output | 1 | User access to a kernel segment |
| wr_en | input | 1 | Write one slot |
| wr_idx | input | 6 | Slot to write |
| wr_vpn | input | 20 | Page number to install |
| wr_asid | input | 6 | Process identifier to install |
| wr_pfn | input | 20 | Frame number to install |
| wr_dirty | input | 1 | Initial modified bit |
| wr_ref | input | 1 | Initial referenced bit |
| wr_writable | input | 1 | 1 = read/write, 0 = read-only |
| inv_en | input | 1 | Invalidate one slot |
| inv_idx | input | 6 | Slot to invalidate |
| inv_all | input | 1 | Invalidate every slot |

## Verification
The bench builds the block with its default parameters: 64 slots, 20-bit page and frame numbers, a 12-bit offset and 6-bit process identifiers. At that size the directed cases can write slot 63 as well as slot 0, and can set up duplicate matches between low and high slots to exercise lowest-index priority. The random phase draws page numbers from a small pool in both the user and kernel virtual segments. Because the pool is small, repeated hits, duplicate matches, protection faults and status-bit updates occur often across the full slot range.

// File: rtl/tlb_pkg.sv
// Package: shared types for the translation buffer.
// Assumes: segment kinds are decoded from the three top address bits.
package tlb_pkg;

    // Kind of address region selected by the top virtual address bits.
    typedef enum logic [1:0] {
        SEG_USER     = 2'd0,
        SEG_KPHYS_C  = 2'd1,
        SEG_KPHYS_U  = 2'd2,
        SEG_KVIRT    = 2'd3
    } seg_e;

endpackage

// File: rtl/tlb_seg_decode.sv
// Module: maps the three top virtual address bits to a segment kind.
// Assumes: top[2] is the most significant address bit.
module tlb_seg_decode
    import tlb_pkg::*;
(
    input  logic [2:0] top,
    output seg_e       seg
);

    // Decode: 0xx user, 100 cached physical, 101 uncached physical, 11x kernel virtual.
    always_comb begin
        if (!top[2])      seg = SEG_USER;
        else if (top[1])  seg = SEG_KVIRT;
        else if (top[0])  seg = SEG_KPHYS_U;
        else              seg = SEG_KPHYS_C;
    end

endmodule

// File: rtl/tlb_entry_array.sv
// Module: slot storage with a parallel tag compare and an indexed read port.
// Assumes: invalidate beats software write, software write beats the
// hardware status update; at most one hardware update per cycle.
module tlb_entry_array #(
    parameter int N      = 64,
    parameter int VPN_W  = 20,
    parameter int ASID_W = 6,
    parameter int PFN_W  = 20,
    localparam int IDX_W = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic              wr_dirty,
    input  logic              wr_ref,
    input  logic              wr_writable,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  inv_idx,
    input  logic              inv_all,
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic              upd_dirty,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic [N-1:0]      match,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [PFN_W-1:0]  rd_pfn,
    output logic              rd_dirty,
    output logic              rd_ref,
    output logic              rd_writable
);

    logic              valid_q [N];
    logic [VPN_W-1:0]  vpn_q   [N];
    logic [ASID_W-1:0] asid_q  [N];
    logic [PFN_W-1:0]  pfn_q   [N];
    logic              dirty_q [N];
    logic              ref_q   [N];
    logic              wbl_q   [N];
    logic [N-1:0]      valid_vec;

    // Slot state: reset, invalidate, software fill, hardware status update.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
                vpn_q[i]   <= '0;
                asid_q[i]  <= '0;
                pfn_q[i]   <= '0;
                dirty_q[i] <= 1'b0;
                ref_q[i]   <= 1'b0;
                wbl_q[i]   <= 1'b0;
            end else if (inv_all || (inv_en && inv_idx == IDX_W'(i))) begin
                valid_q[i] <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                valid_q[i] <= 1'b1;
                vpn_q[i]   <= wr_vpn;
                asid_q[i]  <= wr_asid;
                pfn_q[i]   <= wr_pfn;
                dirty_q[i] <= wr_dirty;
                ref_q[i]   <= wr_ref;
                wbl_q[i]   <= wr_writable;
            end else if (upd_en && upd_idx == IDX_W'(i)) begin
                ref_q[i] <= 1'b1;
                if (upd_dirty) dirty_q[i] <= 1'b1;
            end
        end
    end

    // One comparator per slot, all searched in parallel.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g]     = valid_q[g] && (vpn_q[g] == lk_vpn) && (asid_q[g] == lk_asid);
        assign valid_vec[g] = valid_q[g];
    end

    // Read port used by the selector to fetch the winning slot's payload.
    always_comb begin
        rd_pfn      = pfn_q[rd_idx];
        rd_dirty    = dirty_q[rd_idx];
        rd_ref      = ref_q[rd_idx];
        rd_writable = wbl_q[rd_idx];
    end

    // R1: reset leaves every slot invalid.
    a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> (valid_vec == '0));

    // R10: the all-slot invalidate empties the table.
    a_r10_inv_all_clears: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (valid_vec == '0));

    // R13: an unopposed write installs a valid slot with the new page number.
    a_r13_write_installs: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !inv_all && !(inv_en && inv_idx == wr_idx))
        |=> (valid_q[$past(wr_idx)] && vpn_q[$past(wr_idx)] == $past(wr_vpn)));

    // R11: an unopposed hardware update leaves the referenced bit set.
    a_r11_ref_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !inv_all && !(inv_en && inv_idx == upd_idx) && !(wr_en && wr_idx == upd_idx))
        |=> ref_q[$past(upd_idx)]);

endmodule

// File: rtl/tlb_pick.sv
// Module: picks the lowest-numbered matching slot.
// Assumes: several slots may match when software installs duplicates.
module tlb_pick #(
    parameter int N      = 64,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     match,
    output logic [IDX_W-1:0] sel_idx,
    output logic             any
);

    // Priority scan from the top so the lowest index is assigned last.
    always_comb begin
        sel_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) sel_idx = IDX_W'(i);
        end
        any = |match;
    end

    // R12: the chosen slot matches and no lower slot does.
    a_r12_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (match[sel_idx] && ((match & ((N'(1) << sel_idx) - N'(1))) == '0)));

endmodule

// File: rtl/tlb_xlate.sv
// Module: fully associative, process-tagged translation buffer with
// segment bypass and fault reporting.
// Assumes: refill is done by software through the write port; the
// physical address is as wide as the virtual address or wider.
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    parameter int OFF_W   = 12,
    parameter int ASID_W  = 6,
    parameter int PFN_W   = 20,
    localparam int VA_W   = VPN_W + OFF_W,
    localparam int PA_W   = PFN_W + OFF_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_store,
    input  logic              lk_user,
    output logic              lk_hit,
    output logic [PA_W-1:0]   lk_pa,
    output logic              lk_cacheable,
    output logic              lk_dirty,
    output logic              lk_ref,
    output logic              lk_miss_fault,
    output logic              lk_prot_fault,
    output logic              lk_addr_fault,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic              wr_dirty,
    input  logic              wr_ref,
    input  logic              wr_writable,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  inv_idx,
    input  logic              inv_all
);

    seg_e               seg;
    logic [ENTRIES-1:0] match;
    logic [IDX_W-1:0]   sel_idx;
    logic               any;
    logic [PFN_W-1:0]   rd_pfn;
    logic               rd_dirty, rd_ref, rd_writable;
    logic               translated, user_blocked, ro_store, upd_en;

    tlb_seg_decode u_seg (
        .top (lk_va[VA_W-1 -: 3]),
        .seg (seg)
    );

    tlb_entry_array #(
        .N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)
    ) u_arr (
        .clk, .rst_n,
        .wr_en, .wr_idx, .wr_vpn, .wr_asid, .wr_pfn,
        .wr_dirty, .wr_ref, .wr_writable,
        .inv_en, .inv_idx, .inv_all,
        .upd_en    (upd_en),
        .upd_idx   (sel_idx),
        .upd_dirty (lk_store),
        .lk_vpn    (lk_va[VA_W-1:OFF_W]),
        .lk_asid   (lk_asid),
        .match     (match),
        .rd_idx    (sel_idx),
        .rd_pfn    (rd_pfn),
        .rd_dirty  (rd_dirty),
        .rd_ref    (rd_ref),
        .rd_writable (rd_writable)
    );

    tlb_pick #(.N(ENTRIES)) u_pick (
        .clk, .rst_n,
        .match   (match),
        .sel_idx (sel_idx),
        .any     (any)
    );

    // Path qualifiers shared by the outcome logic and the status update.
    always_comb begin
        translated   = (seg == SEG_USER) || (seg == SEG_KVIRT);
        user_blocked = lk_user && (seg != SEG_USER);
        ro_store     = lk_store && !rd_writable;
        upd_en       = lk_req && !user_blocked && translated && any && !ro_store;
    end

    // Outcome: address fault, physical bypass, hit, protection or miss fault.
    always_comb begin
        lk_hit        = 1'b0;
        lk_pa         = '0;
        lk_cacheable  = 1'b0;
        lk_dirty      = 1'b0;
        lk_ref        = 1'b0;
        lk_miss_fault = 1'b0;
        lk_prot_fault = 1'b0;
        lk_addr_fault = 1'b0;
        if (lk_req) begin
            if (user_blocked) begin
                lk_addr_fault = 1'b1;
            end else if (!translated) begin
                lk_hit       = 1'b1;
                lk_pa        = PA_W'(lk_va[VA_W-4:0]);
                lk_cacheable = (seg == SEG_KPHYS_C);
            end else if (any) begin
                lk_dirty = rd_dirty;
                lk_ref   = rd_ref;
                if (ro_store) begin
                    lk_prot_fault = 1'b1;
                end else begin
                    lk_hit       = 1'b1;
                    lk_pa        = {rd_pfn, lk_va[OFF_W-1:0]};
                    lk_cacheable = 1'b1;
                end
            end else begin
                lk_miss_fault = 1'b1;
            end
        end
    end

    // R9: outcomes are mutually exclusive.
    a_r9_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lk_hit, lk_miss_fault, lk_prot_fault, lk_addr_fault}));

    // R9: no outcome without a request.
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |-> !(lk_hit || lk_miss_fault || lk_prot_fault || lk_addr_fault));

    // R5: kernel physical windows always succeed with the top bits cleared.
    a_r5_phys_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !lk_user && lk_va[VA_W-1 -: 2] == 2'b10)
        |-> (lk_hit && lk_pa[VA_W-4:0] == lk_va[VA_W-4:0]));

    // R6: user access above the user segment faults.
    a_r6_user_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && lk_user && lk_va[VA_W-1]) |-> (lk_addr_fault && !lk_hit));

    // R7: a protection fault only comes from a store.
    a_r7_prot_on_store: assert property (@(posedge clk) disable iff (!rst_n)
        lk_prot_fault |-> lk_store);

endmodule

// File: tb/tlb_xlate_tb.sv
module tlb_xlate_tb;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic        lk_req, lk_store, lk_user;
    logic [31:0] lk_va;
    logic [5:0]  lk_asid;
    logic        lk_hit, lk_cacheable, lk_dirty, lk_ref;
    logic        lk_miss_fault, lk_prot_fault, lk_addr_fault;
    logic [31:0] lk_pa;
    logic        wr_en, wr_dirty, wr_ref, wr_writable;
    logic [5:0]  wr_idx, wr_asid, inv_idx;
    logic [19:0] wr_vpn, wr_pfn;
    logic        inv_en, inv_all;

    tlb_xlate u_dut (.*);

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic        m_v    [64];
    logic [19:0] m_vpn  [64];
    logic [5:0]  m_asid [64];
    logic [19:0] m_pfn  [64];
    logic        m_d [64], m_r [64], m_w [64];

    // Reference model. Flag order: hit, miss, prot, addr, cacheable, dirty, ref.
    function automatic void predict(input logic [31:0] va, input logic [5:0] asid,
                                    input logic st, input logic us, input logic rq,
                                    output logic [6:0] f, output logic [31:0] pa,
                                    output int idx, output logic upd);
        f = '0; pa = '0; idx = -1; upd = 1'b0;
        if (!rq) return;
        if (us && va[31]) begin f[3] = 1'b1; return; end
        if (va[31:30] == 2'b10) begin
            f[6] = 1'b1; f[2] = !va[29]; pa = {3'b000, va[28:0]}; return;
        end
        for (int i = 63; i >= 0; i--)
            if (m_v[i] && m_vpn[i] == va[31:12] && m_asid[i] == asid) idx = i;
        if (idx < 0) begin f[5] = 1'b1; return; end
        f[1] = m_d[idx]; f[0] = m_r[idx];
        if (st && !m_w[idx]) begin f[4] = 1'b1; return; end
        f[6] = 1'b1; f[2] = 1'b1; pa = {m_pfn[idx], va[11:0]}; upd = 1'b1;
    endfunction

    task automatic compare(input string tag, input logic [6:0] ef, input logic [31:0] ep);
        logic [6:0] af;
        af = {lk_hit, lk_miss_fault, lk_prot_fault, lk_addr_fault, lk_cacheable, lk_dirty, lk_ref};
        checks++;
        if (af !== ef || lk_pa !== ep) begin
            errors++;
            $display("FAIL %s: flags=%b pa=%h expected flags=%b pa=%h", tag, af, lk_pa, ef, ep);
        end
    endtask

    // Drive one lookup, check outputs mid-cycle, then apply status updates to the model.
    task automatic look(input string tag, input logic [31:0] va, input logic [5:0] asid,
                        input logic st, input logic us, input logic rq);
        logic [6:0] ef; logic [31:0] ep; int idx; logic upd;
        @(negedge clk);
        lk_va = va; lk_asid = asid; lk_store = st; lk_user = us; lk_req = rq;
        #1;
        predict(va, asid, st, us, rq, ef, ep, idx, upd);
        compare(tag, ef, ep);
        @(posedge clk); #1;
        if (upd) begin m_r[idx] = 1'b1; if (st) m_d[idx] = 1'b1; end
        lk_req = 1'b0;
    endtask

    task automatic wr(input int idx, input logic [19:0] vpn, input logic [5:0] asid,
                      input logic [19:0] pfn, input logic d, input logic r, input logic w);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'(idx); wr_vpn = vpn; wr_asid = asid; wr_pfn = pfn;
        wr_dirty = d; wr_ref = r; wr_writable = w;
        @(posedge clk); #1;
        wr_en = 1'b0;
        m_v[idx] = 1'b1; m_vpn[idx] = vpn; m_asid[idx] = asid; m_pfn[idx] = pfn;
        m_d[idx] = d; m_r[idx] = r; m_w[idx] = w;
    endtask

    task automatic inv(input int idx);
        @(negedge clk);
        inv_en = 1'b1; inv_idx = 6'(idx);
        @(posedge clk); #1;
        inv_en = 1'b0; m_v[idx] = 1'b0;
    endtask

    task automatic inv_every();
        @(negedge clk);
        inv_all = 1'b1;
        @(posedge clk); #1;
        inv_all = 1'b0;
        for (int i = 0; i < 64; i++) m_v[i] = 1'b0;
    endtask

    function automatic logic [19:0] pool_vpn();
        return (($urandom % 2) != 0 ? 20'hC0040 : 20'h00040) + 20'($urandom % 8);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog (R1..): actual=still running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [6:0] ef; logic [31:0] ep; int ix; logic up;
        void'($urandom(32'd2024));
        for (int i = 0; i < 64; i++) begin
            m_v[i] = 0; m_vpn[i] = 0; m_asid[i] = 0; m_pfn[i] = 0;
            m_d[i] = 0; m_r[i] = 0; m_w[i] = 0;
        end
        rst_n = 1'b0; lk_req = 0; lk_va = 0; lk_asid = 0; lk_store = 0; lk_user = 0;
        wr_en = 0; wr_idx = 0; wr_vpn = 0; wr_asid = 0; wr_pfn = 0;
        wr_dirty = 0; wr_ref = 0; wr_writable = 0; inv_en = 0; inv_idx = 0; inv_all = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: empty after reset.
        look("R1 idle after reset", 32'h0001_2345, 6'd0, 0, 0, 0);
        look("R1 miss after reset", 32'h0001_2345, 6'd0, 0, 0, 1);
        look("R1 kvirt miss after reset", 32'hC000_0010, 6'd3, 0, 0, 1);

        // R2 basic translation, R3 identifier isolation.
        wr(0, 20'h00123, 6'd1, 20'hABCDE, 0, 0, 1);
        look("R2 hit", 32'h0012_3456, 6'd1, 0, 1, 1);
        look("R3 other asid misses", 32'h0012_3456, 6'd2, 0, 1, 1);
        wr(5, 20'h00123, 6'd2, 20'h11111, 0, 0, 1);
        look("R3 asid 2 frame", 32'h0012_3FFF, 6'd2, 0, 0, 1);
        look("R3 asid 1 frame", 32'h0012_3000, 6'd1, 0, 0, 1);

        // R4 kernel virtual through slot 63.
        wr(63, 20'hC0001, 6'd1, 20'h00042, 1, 1, 1);
        look("R4 kvirt hit", 32'hC000_1ABC, 6'd1, 0, 0, 1);
        look("R4 user seg translated", 32'h7FFF_F000, 6'd1, 0, 0, 1);

        // R5 physical windows.
        look("R5 cached window", 32'h8123_4567, 6'd9, 1, 0, 1);
        look("R5 uncached window", 32'hBFFF_FFFF, 6'd9, 0, 0, 1);

        // R6 user into kernel segments.
        look("R6 user to cached window", 32'h8000_0000, 6'd1, 0, 1, 1);
        look("R6 user to uncached window", 32'hA000_1000, 6'd1, 0, 1, 1);
        look("R6 user to kvirt", 32'hC000_1ABC, 6'd1, 0, 1, 1);

        // R7 protection, R8 miss, R9 idle.
        wr(7, 20'h00777, 6'd4, 20'h0F0F0, 0, 0, 0);
        look("R7 store to read-only", 32'h0077_7010, 6'd4, 1, 0, 1);
        look("R7 load from read-only", 32'h0077_7010, 6'd4, 0, 0, 1);
        look("R8 miss", 32'h0077_8010, 6'd4, 0, 0, 1);
        look("R9 no request", 32'h0077_7010, 6'd4, 1, 0, 0);

        // R11 status bits.
        wr(9, 20'h00900, 6'd3, 20'h09009, 0, 0, 1);
        look("R11 first load shows clear ref", 32'h0090_0004, 6'd3, 0, 0, 1);
        look("R11 ref now set", 32'h0090_0004, 6'd3, 0, 0, 1);
        look("R11 store shows clean", 32'h0090_0008, 6'd3, 1, 0, 1);
        look("R11 dirty now set", 32'h0090_0008, 6'd3, 0, 0, 1);
        // R11 same-cycle software write beats the hardware update.
        @(negedge clk);
        lk_va = 32'h0090_000C; lk_asid = 6'd3; lk_store = 1; lk_user = 0; lk_req = 1;
        wr_en = 1; wr_idx = 6'd9; wr_vpn = 20'h00900; wr_asid = 6'd3; wr_pfn = 20'h09009;
        wr_dirty = 0; wr_ref = 0; wr_writable = 1;
        #1;
        predict(lk_va, lk_asid, 1'b1, 1'b0, 1'b1, ef, ep, ix, up);
        compare("R11 lookup during write", ef, ep);
        @(posedge clk); #1;
        lk_req = 0; wr_en = 0; m_d[9] = 0; m_r[9] = 0;
        look("R11 write overrode update", 32'h0090_000C, 6'd3, 0, 0, 1);

        // R12 duplicates, R10 invalidation.
        wr(10, 20'h00AAA, 6'd5, 20'h0000A, 0, 0, 1);
        wr(3,  20'h00AAA, 6'd5, 20'h00003, 0, 0, 1);
        look("R12 lowest slot wins", 32'h00AA_A100, 6'd5, 0, 0, 1);
        inv(3);
        look("R10 single invalidate", 32'h00AA_A100, 6'd5, 0, 0, 1);
        @(negedge clk);
        inv_en = 1; inv_idx = 6'd12; wr_en = 1; wr_idx = 6'd12; wr_vpn = 20'h00CCC;
        wr_asid = 6'd5; wr_pfn = 20'h0000C; wr_dirty = 0; wr_ref = 0; wr_writable = 1;
        @(posedge clk); #1;
        inv_en = 0; wr_en = 0; m_v[12] = 0;
        look("R10 invalidate beats write", 32'h00CC_C000, 6'd5, 0, 0, 1);

        // R13 overwrite.
        wr(0, 20'h00321, 6'd1, 20'h55555, 0, 0, 1);
        look("R13 old mapping gone", 32'h0012_3456, 6'd1, 0, 0, 1);
        look("R13 new mapping", 32'h0032_1456, 6'd1, 0, 0, 1);

        inv_every();
        look("R10 all invalid slot 63", 32'hC000_1ABC, 6'd1, 0, 0, 1);
        look("R10 all invalid slot 5", 32'h0012_3000, 6'd2, 0, 0, 1);

        // Random mix over the whole slot range.
        for (int n = 0; n < 600; n++) begin
            int k;
            k = int'($urandom % 20);
            if (k < 6) begin
                wr(int'($urandom % 64), pool_vpn(), 6'($urandom % 3), 20'($urandom),
                   1'($urandom), 1'($urandom), 1'($urandom));
            end else if (k < 8) begin
                inv(int'($urandom % 64));
            end else if (k == 8 && ($urandom % 8) == 0) begin
                inv_every();
            end else begin
                logic [31:0] va;
                int kind;
                kind = int'($urandom % 5);
                if (kind < 3) va = {pool_vpn(), 12'($urandom)};
                else if (kind == 3) va = {2'b10, 30'($urandom)};
                else va = $urandom;
                look("R2 R4 R7 R8 R11 R12 random lookup", va, 6'($urandom % 3),
                     1'($urandom), ($urandom % 4) == 0, ($urandom % 8) != 0);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule